// File: doc/BRIEF.md
# Page-Write Parallel EEPROM Emulator

This block models the device side of a byte-wide parallel EEPROM on a synchronous fabric. The host bus arrives as active-low chip enable, output enable and write enable, a 19-bit address and an 8-bit data bus. The data bus is split into an input byte, an output byte and an output-enable flag. The three strobes are resynchronized to the system clock. Reads then behave like a static RAM with a fixed latency. Write strobes load bytes into a 128-entry page buffer, and each buffer entry has a loaded flag.

A load window stays open for as long as each new write strobe begins within a set number of cycles of the end of the previous one. When the window lapses, the block enters a programming period of fixed length. During that period a walker copies only the flagged buffer entries into a small backing array. While programming runs, further write strobes are dropped. A read of the most recently written address during that time returns its data with the top bit inverted, so the host can poll for completion. Both durations are parameters counted in clock cycles.

Top module: `eeprom_page_emu`

## Requirements
- R1: With chip enable and output enable low and write enable high, `dq_oe` is 1 and `dq_out` carries the byte stored at `addr[STORE_AW-1:0]`. Both update on the third rising clock edge after the pins change, because two synchronizer stages and one output register lie in the path.
- R2: Whenever the synchronized chip enable or output enable is high, `dq_oe` is 0 and `dq_out` is 0.
- R3: A write strobe is the interval in which chip enable and write enable are both low. It is accepted only if output enable is high when it begins. The address is taken when the strobe begins and the data when it ends. Either enable may be the one that falls last or rises first. A strobe that begins with output enable low stores nothing.
- R4: Address bits 18..7 name the page and bits 6..0 the byte within it. The page is latched by the first byte of a window. Bytes may arrive in any order, and a byte loaded twice keeps its last value.
- R5: Each accepted byte restarts a window of `LOAD_WIN_CYC` cycles. A new strobe that begins inside the window extends the page. Otherwise programming starts, and until then reads return the old array contents.
- R6: Programming commits only the bytes flagged in the current window. Other bytes of the page keep their previous values.
- R7: For `PROG_CYC` cycles of programming, a read of the last written address returns its data with bit 7 inverted and bits 6..0 true. Afterwards the same read returns the true data.
- R8: Write strobes that begin during programming change neither the array nor the polled address.
- R9: A byte whose page bits differ from the latched page sets `page_err`, which stays 1 until reset.
- R10: Reset clears `dq_oe`, `page_err`, the load window and the programming state.
- R11: The loaded flags are cleared when programming ends, so a later window never re-commits bytes from an earlier one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | 19 | Byte address: page in 18..7, byte in 6..0 |
| dq_in | input | 8 | Data bus as driven by the host |
| dq_out | output | 8 | Data bus as driven by the device |
| dq_oe | output | 1 | Device drives the data bus when 1 |
| page_err | output | 1 | Sticky page-address mismatch flag |

## Verification
The assertions run on every cycle. They cover the following: the output enable drops after a high chip or output enable, no write is open while programming, the polled byte and address hold still during programming, programming is entered only with at least one flagged byte and no open strobe, the flags are empty once programming ends, and the error flag stays set. Some behaviours only the bench scenarios can show. These are: the ordering and overwriting of bytes inside a page, a byte left untouched beside committed neighbours, window expiry against a timed read, and a later window that leaves earlier committed bytes intact. A behavioural reference model, fed the same pins, predicts the bus outputs on every clock.

// File: rtl/eep_pkg.sv
package eep_pkg;
  localparam int ADDR_W     = 19;
  localparam int DATA_W     = 8;
  localparam int PAGE_BITS  = 7;
  localparam int PAGE_BYTES = 1 << PAGE_BITS;
  localparam int PAGE_W     = ADDR_W - PAGE_BITS;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] byte_t;
  typedef logic [PAGE_W-1:0] page_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_LOAD = 2'd1,
    PH_PROG = 2'd2
  } phase_t;
endpackage

// File: rtl/eep_strobe_sync.sv
module eep_strobe_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_line
      logic [STAGES-1:0] sh;
      always_ff @(posedge clk) begin
        if (rst) sh <= '1;
        else     sh <= {sh[STAGES-2:0], d[i]};
      end
      assign q[i] = sh[STAGES-1];
    end
  endgenerate
endmodule

// File: rtl/eep_page_buf.sv
module eep_page_buf #(
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 7,
  localparam int DEPTH    = 1 << PAGE_BITS
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ld_en,
  input  logic [PAGE_BITS-1:0] ld_col,
  input  logic [DATA_W-1:0]    ld_data,
  input  logic                 clr,
  input  logic [PAGE_BITS-1:0] rd_col,
  output logic [DATA_W-1:0]    rd_data,
  output logic                 rd_flag,
  output logic [DEPTH-1:0]     flags
);
  logic [DATA_W-1:0] slot [DEPTH];
  logic [DEPTH-1:0]  flag_q;

  always_ff @(posedge clk) begin
    if (ld_en) slot[ld_col] <= ld_data;
  end

  always_ff @(posedge clk) begin
    if (rst || clr) flag_q <= '0;
    else if (ld_en) flag_q[ld_col] <= 1'b1;
  end

  assign rd_data = slot[rd_col];
  assign rd_flag = flag_q[rd_col];
  assign flags   = flag_q;
endmodule

// File: rtl/eep_store.sv
module eep_store #(
  parameter int DATA_W = 8,
  parameter int AW     = 10,
  localparam int DEPTH = 1 << AW
) (
  input  logic              clk,
  input  logic              we,
  input  logic [AW-1:0]     waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
    rdata <= cells[raddr];
  end
endmodule

// File: rtl/eeprom_page_emu.sv
module eeprom_page_emu
  import eep_pkg::*;
#(
  parameter int STORE_AW     = 10,
  parameter int LOAD_WIN_CYC = 18750,
  parameter int PROG_CYC     = 1250000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dq_in,
  output logic [DATA_W-1:0] dq_out,
  output logic              dq_oe,
  output logic              page_err
);
  localparam int WIN_W  = $clog2(LOAD_WIN_CYC + 1);
  localparam int PROG_W = $clog2(PROG_CYC + 1);
  localparam int BANK_W = STORE_AW - PAGE_BITS;
  localparam logic [WIN_W-1:0]  WIN_LOAD  = WIN_W'(LOAD_WIN_CYC - 1);
  localparam logic [PROG_W-1:0] PROG_LOAD = PROG_W'(PROG_CYC - 1);

  // synchronized strobes
  logic [2:0] ctl_s;
  logic ce_s, oe_s, we_s;

  eep_strobe_sync #(.N(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ce_n, oe_n, we_n}),
    .q   (ctl_s)
  );
  assign ce_s = ctl_s[2];
  assign oe_s = ctl_s[1];
  assign we_s = ctl_s[0];

  // control state
  phase_t              phase;
  logic                act, act_q, wr_open;
  logic                busy, start_ok, finish, expire, prog_done;
  logic [WIN_W-1:0]    win_cnt;
  logic [PROG_W-1:0]   prog_cnt;
  logic [PAGE_BITS:0]  cm_idx;
  page_t               page_q;
  addr_t               cap_addr, last_addr;
  byte_t               last_data;

  assign act       = ~ce_s & ~we_s;
  assign busy      = (phase == PH_PROG);
  assign start_ok  = act & ~act_q & oe_s & ~busy;
  assign finish    = ~act & act_q & wr_open;
  assign expire    = (phase == PH_LOAD) & ~wr_open & ~start_ok & (win_cnt == '0);
  assign prog_done = busy & (prog_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      wr_open   <= 1'b0;
      phase     <= PH_IDLE;
      page_q    <= '0;
      cap_addr  <= '0;
      last_addr <= '0;
      last_data <= '0;
      win_cnt   <= '0;
      prog_cnt  <= '0;
      cm_idx    <= '0;
      page_err  <= 1'b0;
    end else begin
      act_q <= act;

      if (start_ok) begin
        wr_open  <= 1'b1;
        cap_addr <= addr;
        if (phase == PH_IDLE) begin
          page_q <= addr[ADDR_W-1:PAGE_BITS];
          phase  <= PH_LOAD;
        end else if (addr[ADDR_W-1:PAGE_BITS] != page_q) begin
          page_err <= 1'b1;
        end
      end

      if (finish) begin
        wr_open   <= 1'b0;
        last_addr <= cap_addr;
        last_data <= dq_in;
        win_cnt   <= WIN_LOAD;
      end else if (phase == PH_LOAD && !wr_open && win_cnt != '0) begin
        win_cnt <= win_cnt - 1'b1;
      end

      if (expire) begin
        phase    <= PH_PROG;
        prog_cnt <= PROG_LOAD;
        cm_idx   <= '0;
      end

      if (busy) begin
        if (prog_done) phase <= PH_IDLE;
        else           prog_cnt <= prog_cnt - 1'b1;
        if (!cm_idx[PAGE_BITS]) cm_idx <= cm_idx + 1'b1;
      end
    end
  end

  // page buffer
  byte_t                 buf_rd;
  logic                  buf_flag;
  logic [PAGE_BYTES-1:0] flags;

  eep_page_buf #(.DATA_W(DATA_W), .PAGE_BITS(PAGE_BITS)) u_buf (
    .clk     (clk),
    .rst     (rst),
    .ld_en   (finish),
    .ld_col  (cap_addr[PAGE_BITS-1:0]),
    .ld_data (dq_in),
    .clr     (prog_done),
    .rd_col  (cm_idx[PAGE_BITS-1:0]),
    .rd_data (buf_rd),
    .rd_flag (buf_flag),
    .flags   (flags)
  );

  // backing array
  logic                cm_we;
  logic [STORE_AW-1:0] cm_addr;
  byte_t               rd_q;

  assign cm_we   = busy & ~cm_idx[PAGE_BITS] & buf_flag;
  assign cm_addr = {page_q[BANK_W-1:0], cm_idx[PAGE_BITS-1:0]};

  eep_store #(.DATA_W(DATA_W), .AW(STORE_AW)) u_store (
    .clk   (clk),
    .we    (cm_we),
    .waddr (cm_addr),
    .wdata (buf_rd),
    .raddr (addr[STORE_AW-1:0]),
    .rdata (rd_q)
  );

  // output stage
  logic en_q, hit_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q  <= 1'b0;
      hit_q <= 1'b0;
    end else begin
      en_q  <= ~ce_s & ~oe_s & we_s;
      hit_q <= busy & (addr == last_addr);
    end
  end

  assign dq_oe  = en_q;
  assign dq_out = !en_q ? '0 :
                  hit_q ? {~last_data[DATA_W-1], last_data[DATA_W-2:0]} : rd_q;
endmodule

// File: rtl/eep_page_chk.sv
module eep_page_chk
  import eep_pkg::*;
(
  input logic                  clk,
  input logic                  rst,
  input logic                  busy,
  input logic                  wr_open,
  input logic [PAGE_BYTES-1:0] flags,
  input addr_t                 last_addr,
  input byte_t                 last_data,
  input logic                  page_err,
  input logic                  dq_oe,
  input logic                  ce_s,
  input logic                  oe_s
);
  p_quiet_r2: assert property (@(posedge clk) disable iff (rst)
    (ce_s | oe_s) |=> !dq_oe);

  p_prog_entry_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> (!$past(wr_open) && $past(flags) != '0));

  p_no_load_busy_r8: assert property (@(posedge clk) disable iff (rst)
    busy |-> !wr_open);

  p_hold_poll_r8: assert property (@(posedge clk) disable iff (rst)
    busy |=> ($stable(last_data) && $stable(last_addr)));

  p_err_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    page_err |=> page_err);

  p_flags_clear_r11: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (flags == '0));
endmodule

bind eeprom_page_emu eep_page_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .busy      (busy),
  .wr_open   (wr_open),
  .flags     (flags),
  .last_addr (last_addr),
  .last_data (last_data),
  .page_err  (page_err),
  .dq_oe     (dq_oe),
  .ce_s      (ce_s),
  .oe_s      (oe_s)
);

// File: tb/test_eeprom_page_emu.sv
module test_eeprom_page_emu;
  import eep_pkg::*;

  localparam int WIN   = 40;
  localparam int PROG  = 300;
  localparam int SAW   = 10;
  localparam int DEPTH = 1 << SAW;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [18:0] addr = '0;
  logic [7:0]  dq_in = '0;
  logic [7:0]  dq_out;
  logic        dq_oe, page_err;

  always #4 clk = ~clk;

  eeprom_page_emu #(.STORE_AW(SAW), .LOAD_WIN_CYC(WIN), .PROG_CYC(PROG)) i_eeprom_page_emu (
    .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe), .page_err(page_err)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp, input string what);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // behavioural reference model
  logic        hc1, hc2, hw1, hw2, ho1, ho2;
  logic        m_act, m_open, m_err;
  int          m_phase, m_cnt, m_pcnt;
  logic [11:0] m_page;
  logic [18:0] m_cap, m_last;
  logic [7:0]  m_ld;
  logic [7:0]  m_buf [128];
  bit          m_flag [128];
  logic [7:0]  m_mem [int];
  logic        e_oe, e_known, e_poll;
  logic [7:0]  e_out;
  bit          m_live = 0;

  always @(posedge clk) begin
    if (rst) begin
      {hc1, hc2, hw1, hw2, ho1, ho2} = 6'h3f;
      m_act = 0; m_open = 0; m_err = 0; m_phase = 0; m_cnt = 0; m_pcnt = 0;
      m_last = '0; m_ld = '0; m_cap = '0; m_page = '0;
      for (int i = 0; i < 128; i++) m_flag[i] = 0;
      e_oe = 0; e_out = '0; e_known = 1; e_poll = 0;
      m_live = 1;
    end else begin
      logic c, w, o, a, beg, fin;
      c = hc2; w = hw2; o = ho2;
      hc2 = hc1; hw2 = hw1; ho2 = ho1;
      hc1 = ce_n; hw1 = we_n; ho1 = oe_n;
      a   = !c && !w;
      beg = a && !m_act && o && (m_phase != 2);
      fin = !a && m_act && m_open;

      e_oe = !c && !o && w;
      e_poll = (m_phase == 2) && (addr == m_last);
      e_known = 1;
      if (!e_oe) e_out = '0;
      else if (e_poll) e_out = {~m_ld[7], m_ld[6:0]};
      else if (m_mem.exists(int'(addr) % DEPTH)) e_out = m_mem[int'(addr) % DEPTH];
      else e_known = 0;

      if (m_phase == 2) begin
        if (m_pcnt == 0) begin
          for (int i = 0; i < 128; i++) begin
            if (m_flag[i]) m_mem[(int'(m_page) * 128 + i) % DEPTH] = m_buf[i];
            m_flag[i] = 0;
          end
          m_phase = 0;
        end else m_pcnt--;
      end else if (beg) begin
        m_open = 1; m_cap = addr;
        if (m_phase == 0) begin m_page = addr[18:7]; m_phase = 1; end
        else if (addr[18:7] != m_page) m_err = 1;
      end else if (fin) begin
        m_open = 0;
        m_buf[m_cap[6:0]] = dq_in; m_flag[m_cap[6:0]] = 1;
        m_last = m_cap; m_ld = dq_in; m_cnt = WIN - 1;
      end else if (m_phase == 1 && !m_open) begin
        if (m_cnt == 0) begin m_phase = 2; m_pcnt = PROG - 1; end
        else m_cnt--;
      end
      m_act = a;
    end
  end

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (m_live && !rst) begin
      check("R2", dq_oe, e_oe, "model dq_oe");
      if (e_oe && e_known) check(e_poll ? "R7" : "R1", dq_out, e_out, "model dq_out");
      check("R9", page_err, m_err, "model page_err");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected below 100000 cycles", cyc);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  task automatic wr(input logic [18:0] a, input logic [7:0] d, input bit ce_ctl = 0);
    @(negedge clk);
    oe_n = 1; addr = a; dq_in = d;
    if (ce_ctl) we_n = 0; else ce_n = 0;
    @(negedge clk);
    if (ce_ctl) ce_n = 0; else we_n = 0;
    repeat (4) @(negedge clk);
    if (ce_ctl) ce_n = 1; else we_n = 1;
    @(negedge clk);
    ce_n = 1; we_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic rd(input logic [18:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    addr = a; we_n = 1; ce_n = 0; oe_n = 0;
    repeat (5) @(negedge clk);
    check(tag, {dq_oe, dq_out}, {1'b1, exp}, "directed read");
    ce_n = 1; oe_n = 1;
    repeat (4) @(negedge clk);
  endtask

  task automatic wait_prog();
    repeat (WIN + PROG + 20) @(negedge clk);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    check("R10", {dq_oe, page_err}, 2'b00, "outputs in reset");
    rst = 0;
    repeat (3) @(negedge clk);

    // R2: bus released when either enable is high
    ce_n = 0; oe_n = 1; we_n = 1;
    repeat (5) @(negedge clk);
    check("R2", dq_oe, 1'b0, "oe high");
    ce_n = 1; oe_n = 0;
    repeat (5) @(negedge clk);
    check("R2", {dq_oe, dq_out}, 9'h0, "ce high");
    oe_n = 1;
    repeat (3) @(negedge clk);

    // R1, R7: single byte, poll then true data
    wr(19'h00005, 8'hA5);
    repeat (WIN + 10) @(negedge clk);
    rd(19'h00005, 8'h25, "R7");
    wait_prog();
    rd(19'h00005, 8'hA5, "R1");

    // R3: chip-enable controlled strobe, plus a second byte
    wr(19'h00006, 8'h3C, 1);
    wr(19'h00009, 8'h99);
    wait_prog();
    rd(19'h00006, 8'h3C, "R3");
    rd(19'h00009, 8'h99, "R3");

    // R3: strobe that begins with output enable low stores nothing
    @(negedge clk);
    addr = 19'h00006; dq_in = 8'hFF; oe_n = 0; ce_n = 0; we_n = 0;
    repeat (4) @(negedge clk);
    we_n = 1;
    repeat (2) @(negedge clk);
    ce_n = 1; oe_n = 1;
    wait_prog();
    rd(19'h00006, 8'h3C, "R3");

    // R5: window still open, then programming with polling
    wr(19'h00005, 8'h15);
    rd(19'h00005, 8'hA5, "R5");
    repeat (WIN) @(negedge clk);
    rd(19'h00005, 8'h95, "R5");
    wait_prog();
    rd(19'h00005, 8'h15, "R5");

    // page 2 initial contents for the R11 scenario
    wr(19'h00103, 8'h11);
    wr(19'h00107, 8'h22);
    wait_prog();

    // R4, R6: out-of-order page load with an overwrite
    wr(19'h00082, 8'h5C);
    wait_prog();
    wr(19'h00083, 8'h01);
    wr(19'h00081, 8'h9A);
    wr(19'h00083, 8'h77);
    wr(19'h00087, 8'hE4);
    repeat (WIN + 10) @(negedge clk);
    rd(19'h00087, 8'h64, "R7");
    wait_prog();
    rd(19'h00081, 8'h9A, "R4");
    rd(19'h00083, 8'h77, "R4");
    rd(19'h00087, 8'hE4, "R4");
    rd(19'h00082, 8'h5C, "R6");

    // R11: later window on page 2 commits only its own byte
    wr(19'h00101, 8'h33);
    wait_prog();
    rd(19'h00103, 8'h11, "R11");
    rd(19'h00107, 8'h22, "R11");
    rd(19'h00101, 8'h33, "R11");

    // R8: strobe during programming is ignored
    wr(19'h00008, 8'h40);
    repeat (WIN + 10) @(negedge clk);
    wr(19'h00009, 8'h55);
    rd(19'h00008, 8'hC0, "R7");
    wait_prog();
    rd(19'h00009, 8'h99, "R8");
    rd(19'h00008, 8'h40, "R8");

    // R9: page mismatch inside a window
    wr(19'h00201, 8'h01);
    check("R9", page_err, 1'b0, "before mismatch");
    wr(19'h00284, 8'h02);
    check("R9", page_err, 1'b1, "after mismatch");
    wait_prog();
    check("R9", page_err, 1'b1, "sticky after programming");

    // R10: reset clears the flag
    @(negedge clk);
    rst = 1;
    repeat (3) @(negedge clk);
    check("R10", {dq_oe, page_err}, 2'b00, "after second reset");
    rst = 0;
    repeat (5) @(negedge clk);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule